// File: doc/BRIEF.md
# Integer Execute-Stage ALU with Product-High Results

This block is the arithmetic unit of a small 32-bit RISC-V style integer core. It takes two operands and a 4-bit operation code and drives one result word. It has no clock, so the result follows the inputs within the same cycle, and the core's register stage captures it downstream.

The operation set covers wrapping addition and subtraction, bitwise logic, three kinds of shift, a signed less-than flag, the low word of a product, the high word of a signed or an unsigned product, and a pass-through of the second operand. Three codes in the 4-bit space have no operation. These codes force the result to zero, so the output stays defined for any code value. No overflow, carry or zero flag is produced.

Top module: `rv_alu`

## Requirements
- R1: Code 0 (0000b) gives a_i + b_i modulo 2^32, with no overflow indication.
- R2: Code 12 (1100b) gives a_i - b_i modulo 2^32.
- R3: Code 4 gives a_i XOR b_i, code 6 gives a_i OR b_i, and code 7 gives a_i AND b_i.
- R4: Code 1 shifts a_i left, code 5 shifts it right and fills with zeros, and code 13 shifts it right and fills with copies of bit 31. All three take the shift amount from b_i[4:0] only, and a shift by 0 returns a_i unchanged.
- R5: Code 2 compares a_i and b_i as two's-complement numbers. It gives 32'd1 when a_i is less than b_i and 32'd0 otherwise.
- R6: Code 8 gives bits [31:0] of the product a_i × b_i.
- R7: Code 9 gives bits [63:32] of the 64-bit product, with both operands taken as signed.
- R8: Code 11 gives bits [63:32] of the 64-bit product, with both operands taken as unsigned.
- R9: Code 15 gives b_i unchanged.
- R10: Codes 3, 10 and 14 give 32'd0 for any operand values.
- R11: The result is combinational. A change on any input shows on result_o without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits [4:0] give the shift amount |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result of the selected operation |

## Verification
On every change of the inputs, the assertions check these properties: addition and subtraction invert each other, the flag from a compare has no bits set above bit 0, a shift by zero returns a_i, an arithmetic shift keeps the sign of a_i, and unused codes give zero. The assertions cannot show that a product high word is correct. That takes the bench's independent 64-bit model, run on the most-negative value times -1, on all-ones operands, and on random operands. The bench scenarios are also needed to show shifts by 31 with the upper bits of b_i set, and compares across the sign boundary where signed and unsigned order disagree.

// File: rtl/rv_alu.sv
module rv_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] result_o
);
  localparam int SHW = $clog2(WIDTH);
  localparam int PW  = 2 * WIDTH;

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_SLL   = 4'd1;
  localparam logic [3:0] OP_SLT   = 4'd2;
  localparam logic [3:0] OP_XOR   = 4'd4;
  localparam logic [3:0] OP_SRL   = 4'd5;
  localparam logic [3:0] OP_OR    = 4'd6;
  localparam logic [3:0] OP_AND   = 4'd7;
  localparam logic [3:0] OP_MUL   = 4'd8;
  localparam logic [3:0] OP_MULH  = 4'd9;
  localparam logic [3:0] OP_MULHU = 4'd11;
  localparam logic [3:0] OP_SUB   = 4'd12;
  localparam logic [3:0] OP_SRA   = 4'd13;
  localparam logic [3:0] OP_PASSB = 4'd15;

  logic [SHW-1:0]   shamt;
  logic [PW-1:0]    prod_ss;
  logic [PW-1:0]    prod_uu;
  logic [WIDTH-1:0] sra_res;
  logic             lt_signed;

  assign shamt     = b_i[SHW-1:0];
  assign prod_ss   = {{WIDTH{a_i[WIDTH-1]}}, a_i} * {{WIDTH{b_i[WIDTH-1]}}, b_i};
  assign prod_uu   = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
  assign sra_res   = $signed(a_i) >>> shamt;
  assign lt_signed = $signed(a_i) < $signed(b_i);

  logic [WIDTH-1:0] res;

  always_comb begin
    case (op_i)
      OP_ADD:   res = a_i + b_i;
      OP_SUB:   res = a_i - b_i;
      OP_XOR:   res = a_i ^ b_i;
      OP_OR:    res = a_i | b_i;
      OP_AND:   res = a_i & b_i;
      OP_SLL:   res = a_i << shamt;
      OP_SRL:   res = a_i >> shamt;
      OP_SRA:   res = sra_res;
      OP_SLT:   res = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_MUL:   res = prod_uu[WIDTH-1:0];
      OP_MULH:  res = prod_ss[PW-1:WIDTH];
      OP_MULHU: res = prod_uu[PW-1:WIDTH];
      OP_PASSB: res = b_i;
      default:  res = '0;
    endcase

    if (op_i == OP_ADD)
      assert_add_inverts_R1: assert (res - b_i == a_i);
    if (op_i == OP_SUB)
      assert_sub_inverts_R2: assert (res + b_i == a_i);
    if ((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && shamt == '0)
      assert_shift_zero_R4: assert (res == a_i);
    if (op_i == OP_SRA)
      assert_sra_sign_R4: assert (res[WIDTH-1] == a_i[WIDTH-1]);
    if (op_i == OP_SLT)
      assert_slt_flag_R5: assert (res[WIDTH-1:1] == '0);
    if (op_i == 4'd3 || op_i == 4'd10 || op_i == 4'd14)
      assert_unused_zero_R10: assert (res == '0);

    result_o = res;
  end
endmodule

// File: tb/rv_alu_tb.sv
module rv_alu_tb;
  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = 4'd3;
  logic [31:0] result;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  rv_alu u_dut (.a_i(a), .b_i(b), .op_i(op), .result_o(result));

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r;
    int signed sx, sy;
    longint signed ps;
    longint unsigned pu;
    sx = x; sy = y;
    ps = longint'(sx) * longint'(sy);
    pu = {32'd0, x} * {32'd0, y};
    r = x;
    case (o)
      4'd0:  return x + y;                           // R1
      4'd12: return x + ~y + 32'd1;                  // R2
      4'd4:  return x ^ y;                           // R3
      4'd6:  return x | y;
      4'd7:  return x & y;
      4'd1:  begin for (int i = 0; i < int'(y[4:0]); i++) r = {r[30:0], 1'b0}; return r; end  // R4
      4'd5:  begin for (int i = 0; i < int'(y[4:0]); i++) r = {1'b0, r[31:1]}; return r; end
      4'd13: begin for (int i = 0; i < int'(y[4:0]); i++) r = {r[31], r[31:1]}; return r; end
      4'd2:  return (sx < sy) ? 32'd1 : 32'd0;       // R5
      4'd8:  return pu[31:0];                        // R6
      4'd9:  return ps[63:32];                       // R7
      4'd11: return pu[63:32];                       // R8
      4'd15: return y;                               // R9
      default: return 32'd0;                         // R10
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
    @(negedge clk);
    op = o; a = x; b = y;
    exp_q.push_back(model(o, x, y));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (result !== e) begin
        fails++;
        $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", t, op, a, b, result, e);
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1;
    tests++;
    if (result !== 32'd0) begin
      fails++;
      $display("FAIL R10 initial unused code actual=%h expected=%h", result, 32'd0);
    end
    // R11: no clock edge between input change and sampling
    a = 32'd7; b = 32'd5; op = 4'd0; #1;
    tests++;
    if (result !== 32'd12) begin
      fails++;
      $display("FAIL R11 comb add actual=%h expected=%h", result, 32'd12);
    end
    op = 4'd12; #1;
    tests++;
    if (result !== 32'd2) begin
      fails++;
      $display("FAIL R11 comb sub actual=%h expected=%h", result, 32'd2);
    end

    drive(4'd0,  32'hFFFF_FFFF, 32'd1, "R1");
    drive(4'd0,  32'h7FFF_FFFF, 32'd1, "R1");
    drive(4'd12, 32'd0, 32'd1, "R2");
    drive(4'd12, 32'h8000_0000, 32'd1, "R2");
    drive(4'd4,  32'hF0F0_1234, 32'h0FF0_FFFF, "R3");
    drive(4'd6,  32'hF000_0001, 32'h0000_00F0, "R3");
    drive(4'd7,  32'hDEAD_BEEF, 32'hFFFF_0000, "R3");
    drive(4'd1,  32'hA5A5_A5A5, 32'd0, "R4");
    drive(4'd1,  32'h0000_0003, 32'd31, "R4");
    drive(4'd5,  32'h8000_0000, 32'd31, "R4");
    drive(4'd13, 32'h8000_0000, 32'd31, "R4");
    drive(4'd13, 32'h8000_00F0, 32'hFFFF_FFE4, "R4");
    drive(4'd5,  32'h8000_00F0, 32'hFFFF_FFE4, "R4");
    drive(4'd13, 32'h4000_0000, 32'd0, "R4");
    drive(4'd2,  32'hFFFF_FFFF, 32'd0, "R5");
    drive(4'd2,  32'd0, 32'hFFFF_FFFF, "R5");
    drive(4'd2,  32'h8000_0000, 32'h7FFF_FFFF, "R5");
    drive(4'd2,  32'd5, 32'd5, "R5");
    drive(4'd8,  32'h8000_0000, 32'hFFFF_FFFF, "R6");
    drive(4'd9,  32'h8000_0000, 32'hFFFF_FFFF, "R7");
    drive(4'd9,  32'h8000_0000, 32'h8000_0000, "R7");
    drive(4'd9,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
    drive(4'd11, 32'h8000_0000, 32'hFFFF_FFFF, "R8");
    drive(4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    drive(4'd15, 32'h1234_5678, 32'hCAFE_F00D, "R9");
    drive(4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
    drive(4'd10, 32'h8000_0000, 32'h1, "R10");
    drive(4'd14, 32'h1234_5678, 32'h9ABC_DEF0, "R10");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      drive(o, $urandom, $urandom, "R1..R10 random");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule